// File: doc/BRIEF.md
# Tagged FIFO command consumer with purge recovery

This block sits in a host protocol engine on the read side of a transmit FIFO whose entries are 36 bits wide: a 4-bit tag over a 32-bit payload. When the schedule controller asks for a packet to be run, the block takes the head entry, checks that it is a start-of-packet command, and presents the decoded routing fields (device address, endpoint, speed, transfer type, data toggle, PID) to the packet builder. It then hands the payload words on, one per cycle, until it meets the end-of-packet tag.

If the transfer fails part way (an underrun or bus timeout reported on the abort input), the block stops streaming. It then throws away the stale words still buffered for that packet, until the FIFO is empty or a new start-of-packet entry reaches the head. That entry stays in the FIFO for the next run. Every run request gets exactly one completion pulse with a result code, so the schedule controller never waits forever: a head word that cannot be decoded and a FIFO that stays empty both produce an error completion.

Top module: `tfp_engine`

## Requirements
- R1: After reset, fifo_pop, cmd_valid, data_valid and done are all low.
- R2: On a run request, a head entry with tag 0x0 and a PID other than 0 is popped. One cycle later cmd_valid pulses for exactly one cycle with the fields taken from fixed payload bits: endpoint 29:23, address 22:16, speed 9:8, type 7:6, toggle 5:4, PID 3:0.
- R3: While a packet is running, each head entry tagged 0x1 is popped and its low 32 bits appear on data_out with a one-cycle data_valid, in FIFO order.
- R4: A head entry tagged 0x2 ends the packet. It is popped, and done pulses with code 0 (ok). Entries behind it are not touched.
- R5: A head entry at run start whose tag is not 0x0, or whose PID is 0, is popped and discarded. No cmd_valid follows, and done pulses with code 2 (decode error).
- R6: An abort during a packet stops streaming with no further data_valid. Entries are then discarded until the FIFO is empty or a tag 0x0 entry reaches the head, and done pulses with code 1 (underrun).
- R7: A tag 0x0 entry that ends a purge is not popped, and a later run request consumes it as a normal command.
- R8: During a packet, a head entry whose tag is neither 0x1 nor 0x2 ends the packet the same way as an abort: purge, then code 1.
- R9: If the FIFO stays empty after a run request, done pulses with code 2 exactly WAIT_LIMIT+1 cycles after the request is sampled, and not earlier.
- R10: Each run request produces exactly one done pulse, one cycle wide, and code 3 never occurs.
- R11: An abort while no packet is running, and a run request while one is already in progress, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_req | input | 1 | Request from the schedule controller to run the next packet |
| abort_req | input | 1 | Underrun or bus timeout on the current packet |
| fifo_empty | input | 1 | Transmit FIFO has no entries |
| fifo_rdata | input | TAG_W+DATA_W | Head entry of the FIFO (show-ahead), tag in the top bits |
| fifo_pop | output | 1 | Removes the head entry at this clock edge |
| cmd_valid | output | 1 | One-cycle strobe: decoded command fields are valid |
| cmd_addr | output | 7 | Device address |
| cmd_ep | output | 7 | Endpoint number |
| cmd_speed | output | 2 | Endpoint speed |
| cmd_type | output | 2 | Transfer type |
| cmd_toggle | output | 2 | Data toggle |
| cmd_pid | output | 4 | Token PID |
| data_valid | output | 1 | One-cycle strobe for data_out |
| data_out | output | DATA_W | Payload of a data entry |
| done | output | 1 | One-cycle completion strobe |
| done_code | output | 2 | Result: 0 ok, 1 underrun, 2 decode error |

## Verification
Random packets are built with random field values, 0 to 5 data words and a random ending: end tag, a new command with no end tag, or an unknown tag. An abort is placed after a random number of data words, and some packets also have stray words and a following command behind them. Comparing the FIFO read position after each run separates a correct purge from one that eats the next command or stops too early. Directed cases isolate the decode-error paths (wrong tag, PID 0) from the empty-FIFO timeout, whose exact latency is measured. Further directed cases show that an abort while idle and a second run request during a packet are ignored.

// File: rtl/tfp_pkg.sv
package tfp_pkg;

   localparam int TAG_SOP  = 0;
   localparam int TAG_DATA = 1;
   localparam int TAG_EOP  = 2;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_WAIT   = 2'd1,
      ST_STREAM = 2'd2,
      ST_PURGE  = 2'd3
   } state_e;

   typedef enum logic [1:0] {
      RES_OK       = 2'd0,
      RES_UNDERRUN = 2'd1,
      RES_DECERR   = 2'd2
   } result_e;

   typedef struct packed {
      logic [6:0] ep;
      logic [6:0] addr;
      logic [1:0] speed;
      logic [1:0] xfer;
      logic [1:0] toggle;
      logic [3:0] pid;
   } cmd_t;

endpackage

// File: rtl/tfp_cmd_decode.sv
module tfp_cmd_decode
   import tfp_pkg::*;
#(
   parameter int TAG_W     = 4,
   parameter int CHECK_PID = 1
) (
   input  logic [TAG_W-1:0] tag,
   input  logic [13:0]      hi_bits,
   input  logic [9:0]       lo_bits,
   output cmd_t             cmd,
   output logic             is_cmd
);

   logic tag_is_sop;

   always_comb begin
      cmd.ep     = hi_bits[13:7];
      cmd.addr   = hi_bits[6:0];
      cmd.speed  = lo_bits[9:8];
      cmd.xfer   = lo_bits[7:6];
      cmd.toggle = lo_bits[5:4];
      cmd.pid    = lo_bits[3:0];
   end

   assign tag_is_sop = (tag == TAG_W'(TAG_SOP));

   generate
      if (CHECK_PID != 0) begin : g_pid_check
         assign is_cmd = tag_is_sop && (lo_bits[3:0] != 4'h0);
      end else begin : g_tag_only
         assign is_cmd = tag_is_sop;
      end
   endgenerate

endmodule

// File: rtl/tfp_wait_timer.sv
module tfp_wait_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);

   localparam int CW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("tfp_wait_timer: LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (cnt != CW'(LIMIT - 1)) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign expired = run && (cnt == CW'(LIMIT - 1));

   AST_TMR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0 && !expired)); // R9

endmodule

// File: rtl/tfp_engine.sv
module tfp_engine
   import tfp_pkg::*;
#(
   parameter int TAG_W      = 4,
   parameter int DATA_W     = 32,
   parameter int WAIT_LIMIT = 16,
   parameter int CHECK_PID  = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run_req,
   input  logic                    abort_req,
   input  logic                    fifo_empty,
   input  logic [TAG_W+DATA_W-1:0] fifo_rdata,
   output logic                    fifo_pop,
   output logic                    cmd_valid,
   output logic [6:0]              cmd_addr,
   output logic [6:0]              cmd_ep,
   output logic [1:0]              cmd_speed,
   output logic [1:0]              cmd_type,
   output logic [1:0]              cmd_toggle,
   output logic [3:0]              cmd_pid,
   output logic                    data_valid,
   output logic [DATA_W-1:0]       data_out,
   output logic                    done,
   output logic [1:0]              done_code
);

   localparam int WORD_W = TAG_W + DATA_W;

   generate
      if (DATA_W < 30) begin : g_bad_data_w
         $error("tfp_engine: DATA_W must hold the command fields (>= 30)");
      end
      if (TAG_W < 2) begin : g_bad_tag_w
         $error("tfp_engine: TAG_W must encode three tags (>= 2)");
      end
   endgenerate

   state_e          st, st_nxt;
   logic [TAG_W-1:0] head_tag;
   cmd_t            head_cmd, cmd_q;
   logic            head_is_cmd;
   logic            tmr_run, tmr_exp;
   logic            ld_cmd, ld_data, fin;
   result_e         fin_code, code_q;

   assign head_tag = fifo_rdata[WORD_W-1 -: TAG_W];

   tfp_cmd_decode #(
      .TAG_W     (TAG_W),
      .CHECK_PID (CHECK_PID)
   ) u_dec (
      .tag     (head_tag),
      .hi_bits (fifo_rdata[29:16]),
      .lo_bits (fifo_rdata[9:0]),
      .cmd     (head_cmd),
      .is_cmd  (head_is_cmd)
   );

   assign tmr_run = (st == ST_WAIT) && fifo_empty;

   tfp_wait_timer #(
      .LIMIT (WAIT_LIMIT)
   ) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (tmr_run),
      .expired (tmr_exp)
   );

   always_comb begin
      st_nxt   = st;
      fifo_pop = 1'b0;
      ld_cmd   = 1'b0;
      ld_data  = 1'b0;
      fin      = 1'b0;
      fin_code = RES_OK;
      unique case (st)
         ST_IDLE: begin
            if (run_req) st_nxt = ST_WAIT;
         end
         ST_WAIT: begin
            if (!fifo_empty) begin
               fifo_pop = 1'b1;
               if (head_is_cmd) begin
                  ld_cmd = 1'b1;
                  st_nxt = ST_STREAM;
               end else begin
                  fin      = 1'b1;
                  fin_code = RES_DECERR;
                  st_nxt   = ST_IDLE;
               end
            end else if (tmr_exp) begin
               fin      = 1'b1;
               fin_code = RES_DECERR;
               st_nxt   = ST_IDLE;
            end
         end
         ST_STREAM: begin
            if (abort_req) begin
               st_nxt = ST_PURGE;
            end else if (!fifo_empty) begin
               if (head_tag == TAG_W'(TAG_DATA)) begin
                  fifo_pop = 1'b1;
                  ld_data  = 1'b1;
               end else if (head_tag == TAG_W'(TAG_EOP)) begin
                  fifo_pop = 1'b1;
                  fin      = 1'b1;
                  fin_code = RES_OK;
                  st_nxt   = ST_IDLE;
               end else begin
                  st_nxt = ST_PURGE;
               end
            end
         end
         ST_PURGE: begin
            if (fifo_empty || head_tag == TAG_W'(TAG_SOP)) begin
               fin      = 1'b1;
               fin_code = RES_UNDERRUN;
               st_nxt   = ST_IDLE;
            end else begin
               fifo_pop = 1'b1;
            end
         end
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         cmd_valid  <= 1'b0;
         data_valid <= 1'b0;
         done       <= 1'b0;
         cmd_q      <= '0;
         code_q     <= RES_OK;
         data_out   <= '0;
      end else begin
         st         <= st_nxt;
         cmd_valid  <= ld_cmd;
         data_valid <= ld_data;
         done       <= fin;
         if (ld_cmd)  cmd_q    <= head_cmd;
         if (ld_data) data_out <= fifo_rdata[DATA_W-1:0];
         if (fin)     code_q   <= fin_code;
      end
   end

   assign cmd_addr   = cmd_q.addr;
   assign cmd_ep     = cmd_q.ep;
   assign cmd_speed  = cmd_q.speed;
   assign cmd_type   = cmd_q.xfer;
   assign cmd_toggle = cmd_q.toggle;
   assign cmd_pid    = cmd_q.pid;
   assign done_code  = code_q;

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (done_code != 2'd3)); // R10
   AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid); // R2
   AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> !fifo_empty); // R6
   AST_KEEP_SOP: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PURGE && !fifo_empty && head_tag == TAG_W'(TAG_SOP)) |-> !fifo_pop); // R7
   AST_NO_EARLY_TMO: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && fifo_empty && !tmr_exp) |=> !done); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !fifo_pop); // R11
   AST_ABORT_STOPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STREAM && abort_req) |=> !data_valid); // R6

endmodule

// File: tb/sim_tfp_engine.sv
module sim_tfp_engine;

   localparam int TMO   = 16;
   localparam int MEM_N = 8192;

   logic        clk = 1'b0;
   logic        rst_n, run_req, abort_req, flush;
   logic        fifo_empty, fifo_pop, cmd_valid, data_valid, done;
   logic [35:0] fifo_rdata;
   logic [6:0]  cmd_addr, cmd_ep;
   logic [1:0]  cmd_speed, cmd_type, cmd_toggle, done_code;
   logic [3:0]  cmd_pid;
   logic [31:0] data_out;

   always #10 clk = ~clk;

   logic [35:0] mem [0:MEM_N-1];
   int rd_ptr = 0;
   int wr_ptr = 0;
   int total  = 0;
   int bad    = 0;
   int cyc    = 0;

   assign fifo_empty = (rd_ptr == wr_ptr);
   assign fifo_rdata = mem[rd_ptr % MEM_N];

   always @(posedge clk) begin
      if (flush) rd_ptr <= wr_ptr;
      else if (fifo_pop && !fifo_empty) rd_ptr <= rd_ptr + 1;
   end

   tfp_engine #(.WAIT_LIMIT(TMO)) u0 (
      .clk(clk), .rst_n(rst_n), .run_req(run_req), .abort_req(abort_req),
      .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop),
      .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_ep(cmd_ep),
      .cmd_speed(cmd_speed), .cmd_type(cmd_type), .cmd_toggle(cmd_toggle),
      .cmd_pid(cmd_pid), .data_valid(data_valid), .data_out(data_out),
      .done(done), .done_code(done_code)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic logic [35:0] mk_sop(input logic [6:0] ep, input logic [6:0] addr,
      input logic [1:0] spd, input logic [1:0] typ, input logic [1:0] tog, input logic [3:0] pid);
      return {4'h0, 2'b00, ep, addr, 6'b000000, spd, typ, tog, pid};
   endfunction

   function automatic logic [35:0] mk_word(input logic [3:0] tag, input logic [31:0] d);
      return {tag, d};
   endfunction

   function automatic logic [35:0] rnd_sop();
      logic [3:0] pid;
      pid = 4'($urandom_range(1, 15));
      return mk_sop(7'($urandom), 7'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), pid);
   endfunction

   task automatic push(input logic [35:0] w);
      mem[wr_ptr % MEM_N] = w;
      wr_ptr++;
   endtask

   task automatic do_flush();
      @(negedge clk) flush = 1'b1;
      @(negedge clk) flush = 1'b0;
   endtask

   // reference expectations
   int          exp_code, exp_nd, exp_end;
   bit          exp_cmd, exp_tmo;
   logic [31:0] exp_data [0:63];

   task automatic predict(input int k);
      int p;
      bit fin;
      p = rd_ptr; exp_nd = 0; exp_cmd = 0; exp_tmo = 0;
      if (p == wr_ptr) begin
         exp_code = 2; exp_end = p; exp_tmo = 1;
         return;
      end
      if (mem[p % MEM_N][35:32] != 4'h0 || mem[p % MEM_N][3:0] == 4'h0) begin
         exp_code = 2; exp_end = p + 1;
         return;
      end
      exp_cmd = 1; p++; fin = 0;
      while (!fin) begin
         if ((k >= 0 && exp_nd == k) || p == wr_ptr ||
             (mem[p % MEM_N][35:32] != 4'h1 && mem[p % MEM_N][35:32] != 4'h2)) begin
            while (p < wr_ptr && mem[p % MEM_N][35:32] != 4'h0) p++;
            exp_code = 1; fin = 1;
         end else if (mem[p % MEM_N][35:32] == 4'h1) begin
            exp_data[exp_nd] = mem[p % MEM_N][31:0];
            exp_nd++; p++;
         end else begin
            p++; exp_code = 0; fin = 1;
         end
      end
      exp_end = p;
   endtask

   task automatic do_run(input int k, input bit dbl_run);
      int start, nd, ndone, lat, got;
      bit seen, ab_sent;
      logic [35:0] w;
      predict(k);
      start = rd_ptr; w = mem[start % MEM_N];
      nd = 0; ndone = 0; lat = 0; got = 0; seen = 0; ab_sent = 0;
      @(negedge clk) run_req = 1'b1;
      for (int t = 1; t <= 300; t++) begin
         @(negedge clk);
         run_req = 1'b0;
         abort_req = 1'b0;
         if (cmd_valid) begin
            seen = 1;
            check({cmd_ep, cmd_addr, cmd_speed, cmd_type, cmd_toggle, cmd_pid} ==
                  {w[29:23], w[22:16], w[9:8], w[7:6], w[5:4], w[3:0]}, "R2 fields",
                  {cmd_ep, cmd_addr, cmd_speed, cmd_type, cmd_toggle, cmd_pid},
                  {w[29:23], w[22:16], w[9:8], w[7:6], w[5:4], w[3:0]});
            if (dbl_run) run_req = 1'b1;   // R11: ignored while busy
         end
         if (data_valid) begin
            check(nd < exp_nd && data_out == exp_data[nd], "R3 data", data_out,
                  (nd < exp_nd) ? exp_data[nd] : 32'hdead);
            nd++;
         end
         if (done) begin
            ndone++; got = done_code;
            if (ndone == 1) lat = t;
         end
         if (!ab_sent && seen && k >= 0 && nd == k && ndone == 0) begin
            abort_req = 1'b1; ab_sent = 1;
         end
         if (ndone > 0 && t >= lat + 3) break;
      end
      run_req = 1'b0; abort_req = 1'b0;
      check(ndone == 1, "R10 one completion", ndone, 1);
      check(got == exp_code, (exp_code == 0) ? "R4 code" : (exp_code == 1) ? "R6 R8 code" : "R5 code",
            got, exp_code);
      check(nd == exp_nd, "R3 count", nd, exp_nd);
      check(seen == exp_cmd, "R2 R5 cmd seen", seen, exp_cmd);
      check(rd_ptr == exp_end, "R7 read position", rd_ptr - start, exp_end - start);
      if (exp_tmo) check(lat == TMO + 1, "R9 latency", lat, TMO + 1);
   endtask

   initial begin
      void'($urandom(32'd20240));
      rst_n = 1'b0; run_req = 1'b0; abort_req = 1'b0; flush = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check({fifo_pop, cmd_valid, data_valid, done} == 4'b0, "R1 reset",
            {fifo_pop, cmd_valid, data_valid, done}, 0);

      // R2 R3 R4: plain packet, trailing command kept
      do_flush();
      push(mk_sop(7'h55, 7'h2a, 2'd2, 2'd1, 2'd3, 4'h9));
      push(mk_word(4'h1, 32'h11111111)); push(mk_word(4'h1, 32'h22222222));
      push(mk_word(4'h1, 32'h33333333)); push(mk_word(4'h2, 32'h0));
      push(rnd_sop());
      do_run(-1, 0);
      // zero-length packet
      do_flush();
      push(mk_sop(7'h7f, 7'h7f, 2'd3, 2'd3, 2'd3, 4'hf)); push(mk_word(4'h2, 32'h0));
      do_run(-1, 0);
      // R5: data word at head, PID 0 command
      do_flush();
      push(mk_word(4'h1, 32'h0300290c)); push(rnd_sop()); push(mk_word(4'h2, 0));
      do_run(-1, 0);
      do_run(-1, 0);
      do_flush();
      push(mk_sop(7'h01, 7'h02, 2'd0, 2'd0, 2'd0, 4'h0)); push(mk_word(4'h2, 0));
      do_run(-1, 0);
      // R6 R7: abort after 2 words, stale words, next command survives
      do_flush();
      push(rnd_sop());
      for (int i = 0; i < 5; i++) push(mk_word(4'h1, $urandom));
      push(mk_word(4'h2, 0));
      push(rnd_sop()); push(mk_word(4'h1, 32'hcafe0001)); push(mk_word(4'h2, 0));
      do_run(2, 0);
      do_run(-1, 0);
      // R6: purge to empty
      do_flush();
      push(rnd_sop()); push(mk_word(4'h1, 32'h1)); push(mk_word(4'h1, 32'h2));
      do_run(0, 0);
      // R8: command with no end tag, unknown tag
      do_flush();
      push(rnd_sop()); push(mk_word(4'h1, 32'h5)); push(rnd_sop()); push(mk_word(4'h2, 0));
      do_run(-1, 0);
      do_flush();
      push(rnd_sop()); push(mk_word(4'h7, 32'h9)); push(mk_word(4'h1, 32'h9));
      do_run(-1, 0);
      // R9: empty FIFO timeout
      do_flush();
      do_run(-1, 0);
      // R11: abort while idle, then second run request while busy
      do_flush();
      push(rnd_sop()); push(mk_word(4'h1, 32'habc)); push(mk_word(4'h2, 0));
      begin
         int st0, nd0;
         st0 = rd_ptr; nd0 = 0;
         @(negedge clk) abort_req = 1'b1;
         @(negedge clk) abort_req = 1'b0;
         for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (done) nd0++;
         end
         check(rd_ptr == st0 && nd0 == 0, "R11 idle abort", rd_ptr - st0 + nd0, 0);
      end
      do_run(-1, 1);

      // random mix
      for (int it = 0; it < 60; it++) begin
         int n, kind, k;
         do_flush();
         n = $urandom_range(0, 5);
         if ($urandom_range(0, 7) == 0)
            push(($urandom_range(0, 1) == 0) ? mk_word(4'h1, $urandom)
                                             : mk_sop(7'h3, 7'h4, 2'd0, 2'd0, 2'd0, 4'h0));
         else
            push(rnd_sop());
         for (int i = 0; i < n; i++) push(mk_word(4'h1, $urandom));
         kind = $urandom_range(0, 5);
         if (kind <= 3) push(mk_word(4'h2, 0));
         else if (kind == 4) push(rnd_sop());
         else push(mk_word(4'($urandom_range(3, 15)), $urandom));
         if ($urandom_range(0, 1) == 1) push(mk_word(4'h1, $urandom));
         if ($urandom_range(0, 1) == 1) begin push(rnd_sop()); push(mk_word(4'h2, 0)); end
         k = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, n)) : -1;
         do_run(k, $urandom_range(0, 3) == 0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule